// File: doc/BRIEF.md
# SIMD Saturating Immediate Left Shifter

This unit takes a 128-bit operand and shifts every lane left by an amount packed into an immediate. Each shifted lane is clamped to the range of its destination lane. The 7-bit immediate is split into a 4-bit upper field and a 3-bit lower field. The position of the highest set bit in the upper field picks the lane width: 8, 16, 32 or 64 bits. The whole 7-bit value, minus that lane width, gives the shift count.

A two-bit mode sets the signedness of the source lanes and of the destination lanes. A form input chooses between two ways of working:
- **Scalar:** one lane of the selected width is processed.
- **Vector:** the lane width repeats across a 64-bit or 128-bit datapath, chosen by a width bit.

Results are truncated and never rounded. A sticky saturation flag records that at least one active lane clamped, and it stays set until a clear input resets it. Encodings with no defined meaning are reported on an undefined output, which goes with a zeroed result and leaves the flag alone.

Operations enter through a valid/ready handshake. The result, the undefined indication and the updated flag are registered one cycle after the operation is accepted.

Top module: `sls_unit`

## Requirements
- R1: The lane width is taken from the upper immediate field `imm_hi`:

  | `imm_hi` | Lane width |
  |---|---|
  | `1xxx` | 64 |
  | `01xx` | 32 |
  | `001x` | 16 |
  | `0001` | 8 |

- R2: The shift count is the unsigned value of `{imm_hi, imm_lo}` minus the lane width, which always falls in 0 to lane width − 1.
- R3: An operation is undefined in each of these cases:
  - `mode` is 2'b00;
  - `imm_hi` is 4'b0000, in either form;
  - `scalar`=0 and `wide`=0 while `imm_hi[3]`=1.

  An undefined result returns `out_undef`=1 and `out_data`=0 and leaves `sat_flag` as it was.
- R4: With `mode`=2'b01 (signed source, unsigned destination), a lane whose shifted value is negative gives 0, and a lane whose shifted value is above 2^W−1 gives all ones. Every other lane gives the low W bits of the shifted value.
- R5: With `mode`=2'b10 (signed source, signed destination), results are clamped to the range −2^(W−1) to 2^(W−1)−1.
- R6: With `mode`=2'b11 (unsigned source, unsigned destination), the source lane is zero-extended and the result is clamped to 2^W−1.
- R7: The number of active bits depends on the form:
  - `scalar`=1: the lowest W bits only;
  - `scalar`=0, `wide`=1: all 128 bits;
  - `scalar`=0, `wide`=0: the low 64 bits.

  All output bits above the active part are 0.
- R8: When an accepted defined operation clamps any active lane, `sat_flag` becomes 1. It stays 1 until a cycle with `clr_sat`=1 clears it. If `clr_sat` is high in the same cycle as an accepted operation that saturates, the set wins.
- R9: `in_ready` = !`out_valid` | `out_ready`. The outputs are updated at the edge that accepts an operation. `out_valid`, `out_data` and `out_undef` hold while `out_valid`=1 and `out_ready`=0.
- R10: While `rst_n` is low, `out_valid`, `out_undef`, `out_data` and `sat_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| in_data | input | 128 | Source operand |
| imm_hi | input | 4 | Upper immediate field (lane width and shift high bits) |
| imm_lo | input | 3 | Lower immediate field |
| scalar | input | 1 | 1 = single-lane form, 0 = vector form |
| wide | input | 1 | Vector datapath width: 1 = 128 bits, 0 = 64 bits |
| mode | input | 2 | Signedness mode (00 undefined, 01 signed to unsigned, 10 signed to signed, 11 unsigned to unsigned) |
| clr_sat | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Shifted and clamped result |
| out_undef | output | 1 | Accepted operation had an undefined encoding |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The hold and flag properties assume the following about the inputs:
- inputs are known once reset is released;
- inputs are sampled only at the rising edge;
- the consumer may stall for any number of cycles.

The bench meets this by driving every field on the falling edge and by keeping `out_ready` high except in one dedicated stall sequence.

The lane check assumes that an out-of-range shift count reaches only the lanes of sizes that were not selected. The range assertion is therefore applied only to defined encodings. The sweeps stay within the encodings the requirements define, and the undefined ones are driven on purpose.

// File: rtl/sls_pkg.sv
package sls_pkg;
  localparam int NUM_SIZES  = 4;
  localparam int MIN_LANE_W = 8;
  localparam int SHAMT_W    = 6;

  typedef enum logic [1:0] {
    MODE_RSVD = 2'b00,
    MODE_S2U  = 2'b01,
    MODE_S2S  = 2'b10,
    MODE_U2U  = 2'b11
  } mode_e;

  typedef struct packed {
    logic [1:0]         size_idx;
    logic [SHAMT_W-1:0] shamt;
    logic               src_uns;
    logic               dst_uns;
    logic               undef;
  } dec_t;
endpackage

// File: rtl/sls_decode.sv
module sls_decode
  import sls_pkg::*;
(
  input  logic [3:0] imm_hi,
  input  logic [2:0] imm_lo,
  input  logic       scalar,
  input  logic       wide,
  input  logic [1:0] mode,
  output dec_t       dec
);
  logic [6:0] packed_imm;
  logic [6:0] esize;
  logic [6:0] diff;
  logic [1:0] sidx;
  logic       enc_bad;

  always_comb begin
    casez (imm_hi)
      4'b1???: sidx = 2'd3;
      4'b01??: sidx = 2'd2;
      4'b001?: sidx = 2'd1;
      default: sidx = 2'd0;
    endcase
    esize      = 7'(MIN_LANE_W) << sidx;
    packed_imm = {imm_hi, imm_lo};
    diff       = packed_imm - esize;
    enc_bad    = (imm_hi == 4'b0000) || (mode == MODE_RSVD) ||
                 (!scalar && imm_hi[3] && !wide);
    dec.size_idx = sidx;
    dec.shamt    = diff[SHAMT_W-1:0];
    dec.src_uns  = (mode == MODE_U2U);
    dec.dst_uns  = (mode != MODE_S2S);
    dec.undef    = enc_bad;
  end

  always_comb begin
    if (!enc_bad) begin
      assert_shift_range_R2: assert (diff < esize);
    end
  end
endmodule

// File: rtl/sls_lane.sv
module sls_lane #(
  parameter int LANE_W = 8,
  parameter int SH_W   = 6
) (
  input  logic [LANE_W-1:0] x,
  input  logic [SH_W-1:0]   shamt,
  input  logic              src_uns,
  input  logic              dst_uns,
  output logic [LANE_W-1:0] y,
  output logic              sat
);
  localparam int EXT_W = 2 * LANE_W + 1;
  localparam logic [EXT_W-1:0] S_MAX = {{(LANE_W+2){1'b0}}, {(LANE_W-1){1'b1}}};
  localparam logic [EXT_W-1:0] S_MIN = {{(LANE_W+2){1'b1}}, {(LANE_W-1){1'b0}}};
  localparam logic [EXT_W-1:0] U_MAX = {{(LANE_W+1){1'b0}}, {LANE_W{1'b1}}};

  logic [EXT_W-1:0] ext;
  logic [EXT_W-1:0] shifted;
  logic [EXT_W-1:0] hi_lim;
  logic [EXT_W-1:0] lo_lim;
  logic             over;
  logic             under;

  always_comb begin
    ext     = {{(LANE_W+1){x[LANE_W-1] & ~src_uns}}, x};
    shifted = ext << shamt;
    hi_lim  = dst_uns ? U_MAX : S_MAX;
    lo_lim  = dst_uns ? '0 : S_MIN;
    over    = $signed(shifted) > $signed(hi_lim);
    under   = $signed(shifted) < $signed(lo_lim);
    sat     = over | under;
    if (over)       y = hi_lim[LANE_W-1:0];
    else if (under) y = lo_lim[LANE_W-1:0];
    else            y = shifted[LANE_W-1:0];
  end

  // A zero shift with matching source and destination signedness passes the lane through
  always_comb begin
    if (shamt == '0 && src_uns == dst_uns) begin
      assert_identity_R5: assert (!sat && y == x);
    end
  end
endmodule

// File: rtl/sls_unit.sv
module sls_unit
  import sls_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [3:0]        imm_hi,
  input  logic [2:0]        imm_lo,
  input  logic              scalar,
  input  logic              wide,
  input  logic [1:0]        mode,
  input  logic              clr_sat,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_undef,
  output logic              sat_flag
);
  localparam int ACT_W = $clog2(DATA_W) + 1;

  dec_t              dec;
  logic [ACT_W-1:0]  act_w;
  logic [DATA_W-1:0] res_sz [NUM_SIZES];
  logic [NUM_SIZES-1:0] sat_sz;
  logic [DATA_W-1:0] sel_res;
  logic              sel_sat;
  logic              accept;

  logic              valid_nxt;
  logic [DATA_W-1:0] data_nxt;
  logic              undef_nxt;
  logic              flag_nxt;
  logic              load_en;

  sls_decode u_dec (
    .imm_hi (imm_hi),
    .imm_lo (imm_lo),
    .scalar (scalar),
    .wide   (wide),
    .mode   (mode),
    .dec    (dec)
  );

  always_comb begin
    if (scalar)    act_w = ACT_W'(MIN_LANE_W << dec.size_idx);
    else if (wide) act_w = ACT_W'(DATA_W);
    else           act_w = ACT_W'(DATA_W / 2);
  end

  for (genvar gs = 0; gs < NUM_SIZES; gs++) begin : g_size
    localparam int LW = MIN_LANE_W << gs;
    localparam int NL = DATA_W / LW;
    logic [NL-1:0]     lane_sat;
    logic [NL-1:0]     lane_on;
    logic [DATA_W-1:0] lane_res;

    for (genvar e = 0; e < NL; e++) begin : g_lane
      logic [LW-1:0] y;
      logic          s;
      sls_lane #(.LANE_W(LW), .SH_W(SHAMT_W)) u_lane (
        .x       (in_data[e*LW +: LW]),
        .shamt   (dec.shamt),
        .src_uns (dec.src_uns),
        .dst_uns (dec.dst_uns),
        .y       (y),
        .sat     (s)
      );
      assign lane_on[e]              = (ACT_W'((e + 1) * LW) <= act_w);
      assign lane_res[e*LW +: LW]    = lane_on[e] ? y : '0;
      assign lane_sat[e]             = lane_on[e] & s;
    end

    assign res_sz[gs] = lane_res;
    assign sat_sz[gs] = |lane_sat;
  end

  assign sel_res  = res_sz[dec.size_idx];
  assign sel_sat  = sat_sz[dec.size_idx];
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  // next-state
  always_comb begin
    load_en   = accept;
    valid_nxt = accept ? 1'b1 : (out_ready ? 1'b0 : out_valid);
    data_nxt  = dec.undef ? '0 : sel_res;
    undef_nxt = dec.undef;
    flag_nxt  = (clr_sat ? 1'b0 : sat_flag) | (accept && !dec.undef && sel_sat);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_undef <= 1'b0;
      sat_flag  <= 1'b0;
    end else begin
      out_valid <= valid_nxt;
      sat_flag  <= flag_nxt;
      if (load_en) begin
        out_data  <= data_nxt;
        out_undef <= undef_nxt;
      end
    end
  end

  assert_undef_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_undef |-> out_data == '0);

  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag && !clr_sat |=> sat_flag);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_sat && !accept |=> !sat_flag);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_undef));

  assert_undef_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && dec.undef && !clr_sat |=> sat_flag == $past(sat_flag));
endmodule

// File: tb/sls_unit_tb_top.sv
module sls_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_ready, scalar, wide, clr_sat;
  logic         out_valid, out_ready, out_undef, sat_flag;
  logic [127:0] in_data, out_data;
  logic [3:0]   imm_hi;
  logic [2:0]   imm_lo;
  logic [1:0]   mode;

  int n_checks = 0;
  int n_errs   = 0;
  bit model_flag = 1'b0;
  logic [127:0] rnd = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3211;

  always #10 clk = ~clk;

  sls_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .imm_hi(imm_hi), .imm_lo(imm_lo), .scalar(scalar),
    .wide(wide), .mode(mode), .clr_sat(clr_sat), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_undef(out_undef),
    .sat_flag(sat_flag)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void ref_lane(input logic [63:0] x, input int w, input int sh,
                                   input bit su, input bit du,
                                   output logic [63:0] y, output bit s);
    logic signed [131:0] v, hi, lo;
    logic [63:0] m;
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    v = $signed({68'd0, x & m});
    if (!su && x[w-1]) v = v - (132'sd1 <<< w);
    v = v <<< sh;
    hi = du ? ((132'sd1 <<< w) - 132'sd1) : ((132'sd1 <<< (w - 1)) - 132'sd1);
    lo = du ? 132'sd0 : -(132'sd1 <<< (w - 1));
    s = 1'b1;
    if (v > hi)      y = hi[63:0] & m;
    else if (v < lo) y = lo[63:0] & m;
    else begin y = v[63:0] & m; s = 1'b0; end
  endfunction

  function automatic logic [127:0] ref_vec(input logic [127:0] d, input int w, input int sh,
                                           input bit scal, input bit wd,
                                           input logic [1:0] md, output bit anys);
    logic [127:0] r, t;
    logic [63:0] y;
    bit s;
    int nbits;
    r = '0;
    anys = 1'b0;
    nbits = scal ? w : (wd ? 128 : 64);
    for (int e = 0; (e + 1) * w <= nbits; e++) begin
      t = d >> (e * w);
      ref_lane(t[63:0], w, sh, md == 2'b11, md != 2'b10, y, s);
      r = r | ({64'd0, y} << (e * w));
      anys = anys | s;
    end
    return r;
  endfunction

  function automatic logic [127:0] make_pat(input int kind, input int w);
    logic [127:0] d;
    logic [63:0] lv;
    d = '0;
    case (kind)
      0: lv = 64'd1 << (w - 1);
      1: lv = (64'd1 << (w - 1)) - 64'd1;
      2: lv = '1;
      default: lv = 64'd1;
    endcase
    if (w < 64) lv = lv & ((64'd1 << w) - 64'd1);
    for (int e = 0; e * w < 128; e++) d = d | ({64'd0, lv} << (e * w));
    return d;
  endfunction

  task automatic next_rnd();
    rnd = rnd * 128'd6364136223846793005 + 128'd1442695040888963407;
  endtask

  task automatic run_raw(input logic [127:0] d, input logic [3:0] hi, input logic [2:0] lo,
                         input bit scal, input bit wd, input logic [1:0] md,
                         input bit clr, input string tag);
    bit undef, s;
    int w, sh;
    logic [127:0] exp;
    bit exp_flag;
    undef = (hi == 4'b0) || (md == 2'b00) || (!scal && hi[3] && !wd);
    w  = hi[3] ? 64 : hi[2] ? 32 : hi[1] ? 16 : 8;
    sh = int'({hi, lo}) - w;
    s  = 1'b0;
    if (undef) exp = '0;
    else       exp = ref_vec(d, w, sh, scal, wd, md, s);
    exp_flag = (clr ? 1'b0 : model_flag) | (!undef && s);
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b1; in_data = d; imm_hi = hi; imm_lo = lo;
    scalar = scal; wide = wd; mode = md; clr_sat = clr;
    @(negedge clk);
    in_valid = 1'b0; clr_sat = 1'b0;
    check(out_valid == 1'b1, "R9 result valid after accept", 128'(out_valid), 128'd1);
    check(out_undef == undef, "R3 undefined indication", 128'(out_undef), 128'(undef));
    check(out_data == exp, tag, out_data, exp);
    check(sat_flag == exp_flag, "R8 saturation flag", 128'(sat_flag), 128'(exp_flag));
    model_flag = exp_flag;
  endtask

  task automatic run_op(input logic [127:0] d, input int w, input int sh, input bit scal,
                        input bit wd, input logic [1:0] md, input bit clr, input string tag);
    logic [6:0] p;
    p = 7'(w + sh);
    run_raw(d, p[6:3], p[2:0], scal, wd, md, clr, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    string tag;
    logic [127:0] held;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_data = '0; imm_hi = '0;
    imm_lo = '0; scalar = 1'b0; wide = 1'b0; mode = 2'b00; clr_sat = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(out_valid == 1'b0, "R10 out_valid in reset", 128'(out_valid), 128'd0);
    check(sat_flag == 1'b0, "R10 sat_flag in reset", 128'(sat_flag), 128'd0);
    check(out_data == '0, "R10 out_data in reset", out_data, '0);
    check(out_undef == 1'b0, "R10 out_undef in reset", 128'(out_undef), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R9 ready when idle", 128'(in_ready), 128'd1);

    // Sweep: R1 R2 lane width/shift decode, R4 R5 R6 clamps, R7 active lanes
    for (int form = 0; form < 3; form++) begin
      for (int md = 1; md < 4; md++) begin
        for (int gs = 0; gs < 4; gs++) begin
          int w;
          w = 8 << gs;
          for (int sh = 0; sh < w; sh++) begin
            for (int k = 0; k < 6; k++) begin
              logic [127:0] d;
              if (k < 4) d = make_pat(k, w);
              else begin next_rnd(); d = rnd; end
              tag = $sformatf("R1 R2 R7 %s form=%0d w=%0d sh=%0d k=%0d",
                              md == 1 ? "R4" : md == 2 ? "R5" : "R6", form, w, sh, k);
              run_op(d, w, sh, form == 0, form == 2, 2'(md), 1'b1, tag);
            end
          end
        end
      end
    end

    // R8 sticky: saturate, then non-saturating op without clear keeps flag
    run_op(make_pat(1, 8), 8, 7, 1'b0, 1'b1, 2'b10, 1'b1, "R5 saturating op");
    run_op(128'd0, 8, 0, 1'b0, 1'b1, 2'b10, 1'b0, "R8 sticky quiet op");
    // R3 undefined leaves a set flag alone
    run_raw(make_pat(1, 8), 4'b0001, 3'd7, 1'b0, 1'b1, 2'b00, 1'b0, "R3 mode 00");
    // R8 clear with no operation
    @(negedge clk); clr_sat = 1'b1;
    @(negedge clk); clr_sat = 1'b0;
    model_flag = 1'b0;
    check(sat_flag == 1'b0, "R8 clear without op", 128'(sat_flag), 128'd0);
    // R3 undefined saturating data does not set the flag
    run_raw(make_pat(1, 8), 4'b0000, 3'd7, 1'b1, 1'b0, 2'b10, 1'b0, "R3 scalar imm_hi zero");
    run_raw(make_pat(1, 8), 4'b0000, 3'd5, 1'b0, 1'b1, 2'b01, 1'b0, "R3 vector imm_hi zero");
    run_raw(make_pat(1, 64), 4'b1111, 3'd7, 1'b0, 1'b0, 2'b10, 1'b0, "R3 64-bit lanes narrow");
    run_raw(make_pat(1, 64), 4'b1111, 3'd7, 1'b0, 1'b0, 2'b00, 1'b0, "R3 mode 00 narrow");
    // R4 negative input clamps to zero, R6 sign bit treated as magnitude
    run_op(make_pat(0, 32), 32, 0, 1'b0, 1'b1, 2'b01, 1'b1, "R4 negative to zero");
    run_op(make_pat(0, 32), 32, 0, 1'b0, 1'b1, 2'b11, 1'b1, "R6 top bit unsigned");

    // R9 backpressure
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b0; in_data = make_pat(3, 16);
    imm_hi = 4'b0010; imm_lo = 3'd3; scalar = 1'b0; wide = 1'b1; mode = 2'b11;
    @(negedge clk);
    in_valid = 1'b0;
    held = out_data;
    check(out_valid == 1'b1, "R9 valid under stall", 128'(out_valid), 128'd1);
    check(in_ready == 1'b0, "R9 not ready under stall", 128'(in_ready), 128'd0);
    check(held == make_pat(3, 16) << 3, "R9 stalled result value", held, make_pat(3, 16) << 3);
    in_valid = 1'b1; in_data = '1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_data == held, "R9 data held under stall", out_data, held);
    check(out_valid == 1'b1, "R9 valid held", 128'(out_valid), 128'd1);
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 drained", 128'(out_valid), 128'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule